// File: doc/BRIEF.md
# Quad-Sample Marker Engine

This block runs a stream of marker instructions and drives one digital marker output at four samples per clock. It reads 64-bit words from a first-word-fall-through FIFO. The data word is valid whenever the FIFO reports not empty, and the block pops a word by asserting its read strobe for one cycle.

A play instruction holds a level on all four samples for a programmed number of clock cycles, called quad-samples. It then emits a 4-bit transition word for one cycle, so an edge can land on any single sample inside a clock. Two further instructions pause the engine until a trigger pulse or a sync pulse arrives. When the FIFO runs dry, the engine keeps the last held level on the output and raises an idle flag.

The instruction word has these fields:

- Bits 47-46: engine opcode. 0 is play, 1 is wait for trigger, 2 is wait for sync, and 3 is discarded.
- Bit 32: the level to hold.
- Bits 36-33: the transition word.
- Bits 31-0: the count, in quad-samples.
- Bits 63-48 and 45-37 carry no meaning for this block.

Top module: `mke_marker_engine`

## Requirements
- R1: After a synchronous active-high reset, the marker output is 0, idle is high while the FIFO is empty, and no word is popped.
- R2: A play instruction with count N>0, popped at clock edge k, gives all four output bits equal to bit 32 for the N cycles after edge k. The cycle after those shows the transition word.
- R3: A play instruction with count 0 shows only its transition word, for exactly one cycle after the pop edge.
- R4: Transition word bit 33 drives output bit 0, which is the earliest sample in time, up to bit 36 on output bit 3.
- R5: The next instruction is popped in the same cycle that the transition word is on the output, so consecutive play instructions leave no gap.
- R6: Opcode 1 holds the output at the last held level and pops nothing until a trigger pulse is seen at a clock edge. The following instruction is popped at the next edge.
- R7: Opcode 2 behaves the same way, but it is released by the sync input instead of the trigger input.
- R8: Trigger or sync pulses that arrive while the engine is not waiting for that input have no effect and are not remembered.
- R9: While the FIFO is empty and the engine is ready, the output holds the level of the most recent play instruction (0 after reset) and idle is high. Idle is low while holding or waiting.
- R10: Opcode 3 is popped and dropped. It spends one cycle with the held level on the output.
- R11: Bits 63-48 and 45-37 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_data | input | 64 | Head word of the instruction FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Pop strobe, one word per cycle |
| trig_in | input | 1 | Trigger pulse |
| sync_in | input | 1 | Sync pulse |
| mark_out | output | 4 | Four marker samples, bit 0 earliest |
| idle | output | 1 | Ready with an empty FIFO |

## Verification
The bench targets the corner cases below. Each one names the way a broken design would show itself.

- Count zero: a design with an off-by-one in the counter would show an extra held cycle before the transition word, or one too few.
- Back-to-back play instructions: a design that spends a cycle before fetching would insert a held-level gap after each transition word.
- Wrong-input pulses during a wait: a design that decodes the two wait opcodes the wrong way round would release on the wrong input.
- A trigger while idle: a design that latches pulses would pass straight through a later wait.
- Garbage in the reserved bits and discarded opcodes: a design that decodes them would emit wrong levels.

// File: rtl/mke_pkg.sv
package mke_pkg;
    localparam int WORD_W = 64;
    localparam int CNT_W  = 32;
    localparam int SPC    = 4;

    typedef enum logic [1:0] {
        OP_PLAY  = 2'd0,
        OP_WTRIG = 2'd1,
        OP_WSYNC = 2'd2,
        OP_DROP  = 2'd3
    } mop_e;

    typedef enum logic [1:0] {
        S_READY,
        S_HOLD,
        S_WTRIG,
        S_WSYNC
    } mst_e;

    typedef struct packed {
        mop_e             op;
        logic             lvl;
        logic [SPC-1:0]   xw;
        logic [CNT_W-1:0] cnt;
    } minsn_s;

    function automatic minsn_s unpack_insn(input logic [WORD_W-1:0] w);
        minsn_s r;
        r.op  = mop_e'(w[47:46]);
        r.lvl = w[32];
        r.xw  = w[36:33];
        r.cnt = w[31:0];
        return r;
    endfunction

    function automatic logic [SPC-1:0] spread(input logic b);
        return {SPC{b}};
    endfunction
endpackage

// File: rtl/mke_decode.sv
module mke_decode
    import mke_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output minsn_s            fields,
    output logic              cnt_zero
);
    always_comb begin
        fields   = unpack_insn(word);
        cnt_zero = (fields.cnt == '0);
    end
endmodule

// File: rtl/mke_span_cnt.sv
module mke_span_cnt #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/mke_marker_engine.sv
module mke_marker_engine
    import mke_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    input  logic              trig_in,
    input  logic              sync_in,
    output logic [SPC-1:0]    mark_out,
    output logic              idle
);
    minsn_s         dec;
    logic           dec_zero;
    mst_e           st_q;
    logic [SPC-1:0] mark_q;
    logic [SPC-1:0] xw_q;
    logic           hold_lvl;
    logic           span_zero;
    logic           span_load;
    logic           span_dec;

    mke_decode u_dec (
        .word     (fifo_data),
        .fields   (dec),
        .cnt_zero (dec_zero)
    );

    assign fifo_pop  = (st_q == S_READY) && !fifo_empty;
    assign idle      = (st_q == S_READY) && fifo_empty;
    assign span_load = fifo_pop && (dec.op == OP_PLAY) && !dec_zero;
    assign span_dec  = (st_q == S_HOLD) && !span_zero;

    mke_span_cnt #(.CW(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (span_load),
        .load_val (dec.cnt - 1'b1),
        .dec      (span_dec),
        .zero     (span_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_READY;
            mark_q   <= '0;
            xw_q     <= '0;
            hold_lvl <= 1'b0;
        end else begin
            unique case (st_q)
                S_READY: begin
                    mark_q <= spread(hold_lvl);
                    if (!fifo_empty) begin
                        unique case (dec.op)
                            OP_PLAY: begin
                                hold_lvl <= dec.lvl;
                                xw_q     <= dec.xw;
                                if (dec_zero) begin
                                    mark_q <= dec.xw;
                                end else begin
                                    mark_q <= spread(dec.lvl);
                                    st_q   <= S_HOLD;
                                end
                            end
                            OP_WTRIG: st_q <= S_WTRIG;
                            OP_WSYNC: st_q <= S_WSYNC;
                            default:  st_q <= S_READY;
                        endcase
                    end
                end
                S_HOLD: begin
                    if (span_zero) begin
                        mark_q <= xw_q;
                        st_q   <= S_READY;
                    end else begin
                        mark_q <= spread(hold_lvl);
                    end
                end
                S_WTRIG: begin
                    mark_q <= spread(hold_lvl);
                    if (trig_in) st_q <= S_READY;
                end
                S_WSYNC: begin
                    mark_q <= spread(hold_lvl);
                    if (sync_in) st_q <= S_READY;
                end
                default: st_q <= S_READY;
            endcase
        end
    end

    assign mark_out = mark_q;

    // R2
    play_level_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_pop && dec.op == OP_PLAY && !dec_zero)
        |=> (mark_out == {SPC{$past(fifo_data[32])}}) && (st_q == S_HOLD));

    // R3
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_pop && dec.op == OP_PLAY && dec_zero)
        |=> (mark_out == $past(fifo_data[36:33])) && (st_q == S_READY));

    // R6
    trig_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_WTRIG && !trig_in) |=> (st_q == S_WTRIG) && !fifo_pop);

    // R7
    sync_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_WSYNC && !sync_in) |=> (st_q == S_WSYNC) && !fifo_pop);

    // R9
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_READY && fifo_empty) |=> mark_out == {SPC{hold_lvl}});

    // R5
    pop_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_HOLD && span_zero && !fifo_empty) |=> fifo_pop);
endmodule

// File: tb/tb_mke_marker_engine.sv
module tb_mke_marker_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] mem [0:63];
    int          wp = 0;
    int          rp = 0;
    logic [63:0] fifo_data;
    logic        fifo_empty;
    logic        fifo_pop;
    logic        trig_in = 1'b0;
    logic        sync_in = 1'b0;
    logic [3:0]  mark_out;
    logic        idle;
    int          total = 0;
    int          bad = 0;
    logic        cur_lvl = 1'b0;
    logic [3:0]  expq [$];

    always #4 clk = ~clk;

    assign fifo_empty = (rp == wp);
    assign fifo_data  = mem[rp[5:0]];

    always @(posedge clk) if (fifo_pop) rp <= rp + 1;

    mke_marker_engine dut (
        .clk(clk), .rst(rst), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop), .trig_in(trig_in), .sync_in(sync_in),
        .mark_out(mark_out), .idle(idle)
    );

    function automatic logic [63:0] mk(logic [1:0] op, logic lvl, logic [3:0] xw,
                                       logic [31:0] cnt, logic [31:0] junk);
        return {junk[15:0], op, junk[24:16], xw, lvl, cnt};
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(logic [63:0] w);
        mem[wp[5:0]] = w;
        wp = wp + 1;
    endtask

    // R2 R3 R4 R5 R10 R11: stream of play/drop words, optional pokes for R8
    task automatic run_stream(int n, bit poke, int big);
        expq.delete();
        for (int i = 0; i < n; i++) begin
            logic [3:0]  xw   = 4'($urandom);
            logic        lv   = 1'($urandom);
            logic [31:0] cnt  = (i == 0 && big > 0) ? 32'(big) : 32'($urandom % 6);
            logic [31:0] junk = $urandom;
            if ($urandom % 5 == 0) begin
                push(mk(2'd3, lv, xw, cnt, junk));
                expq.push_back({4{cur_lvl}});
            end else begin
                push(mk(2'd0, lv, xw, cnt, junk));
                for (int k = 0; k < int'(cnt); k++) expq.push_back({4{lv}});
                expq.push_back(xw);
                cur_lvl = lv;
            end
        end
        for (int i = 0; i < expq.size(); i++) begin
            @(negedge clk);
            chk("R2/R3/R4/R5/R10/R11 stream", mark_out, expq[i]);
            if (poke && i == 1) begin trig_in = 1'b1; sync_in = 1'b1; end
            if (poke && i == 2) begin trig_in = 1'b0; sync_in = 1'b0; end
        end
        trig_in = 1'b0; sync_in = 1'b0;
        chk("R9 idle after stream", {3'b0, idle}, 4'd1);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R9 held level", mark_out, {4{cur_lvl}});
        end
    endtask

    // R6 R7 R8
    task automatic wait_case(bit use_trig, bit pre_poke);
        logic        nl = ~cur_lvl;
        logic [3:0]  xw = 4'($urandom);
        string       rq = use_trig ? "R6" : "R7";
        if (pre_poke) begin
            if (use_trig) trig_in = 1'b1; else sync_in = 1'b1;
            @(negedge clk);
            trig_in = 1'b0; sync_in = 1'b0;
            @(negedge clk);
        end
        push(mk(use_trig ? 2'd1 : 2'd2, 1'b1, 4'hF, 32'd7, $urandom));
        push(mk(2'd0, nl, xw, 32'd2, $urandom));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk({rq, " waiting holds level"}, mark_out, {4{cur_lvl}});
            chk({rq, " idle low while waiting"}, {3'b0, idle}, 4'd0);
        end
        if (use_trig) sync_in = 1'b1; else trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0; sync_in = 1'b0;
        @(negedge clk);
        chk("R8 wrong pulse ignored", mark_out, {4{cur_lvl}});
        @(negedge clk);
        chk("R8 wrong pulse ignored", mark_out, {4{cur_lvl}});
        if (use_trig) trig_in = 1'b1; else sync_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0; sync_in = 1'b0;
        @(negedge clk);
        chk({rq, " released"}, mark_out, {4{nl}});
        @(negedge clk);
        chk({rq, " released"}, mark_out, {4{nl}});
        @(negedge clk);
        chk({rq, " transition"}, mark_out, xw);
        cur_lvl = nl;
        @(negedge clk);
        chk("R9 held after wait", mark_out, {4{cur_lvl}});
    endtask

    // R8: pulse while idle is not remembered
    task automatic idle_poke_case();
        trig_in = 1'b1; sync_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0; sync_in = 1'b0;
        @(negedge clk);
        push(mk(2'd1, 1'b0, 4'h0, 32'd0, 32'd0));
        push(mk(2'd0, ~cur_lvl, 4'h5, 32'd1, 32'd0));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R8 idle pulse not latched", mark_out, {4{cur_lvl}});
        end
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        @(negedge clk);
        cur_lvl = ~cur_lvl;
        chk("R6 release after idle", mark_out, {4{cur_lvl}});
        @(negedge clk);
        chk("R4 transition 0101", mark_out, 4'h5);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset output", mark_out, 4'h0);
        chk("R1 reset idle", {3'b0, idle}, 4'd1);
        chk("R1 reset no pop", {3'b0, fifo_pop}, 4'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", mark_out, 4'h0);
        // R4 directed: only sample 0 high
        push(mk(2'd0, 1'b1, 4'b0001, 32'd0, 32'd0));
        @(negedge clk);
        chk("R4 bit0 earliest", mark_out, 4'b0001);
        cur_lvl = 1'b1;
        @(negedge clk);
        chk("R9 level after zero count", mark_out, 4'hF);
        run_stream(6, 1'b0, 0);
        run_stream(5, 1'b1, 40);
        for (int t = 0; t < 8; t++) run_stream(2 + ($urandom % 7), 1'($urandom), 0);
        wait_case(1'b1, 1'b0);
        wait_case(1'b0, 1'b0);
        wait_case(1'b1, 1'b1);
        wait_case(1'b0, 1'b1);
        idle_poke_case();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule